// File: doc/BRIEF.md
# CPU Packet Endpoint with Loopback

This block sits between a CPU register bus and a packet link. The CPU builds an outgoing packet by writing 16-bit words one after another into a transmit buffer. It then launches the packet with a self-clearing flush bit in the control register. Incoming packets land in a receive buffer. The CPU drains that buffer one word per read and steers by the status flags, which describe the word at the head of the buffer: available, first of packet and last of packet.

For test, the link is replaced by an internal loopback. A launched packet streams out of the transmit buffer at one word per cycle. When the receive path is enabled and the receive buffer has room for the whole packet, each word goes straight into the receive buffer. Otherwise the packet is discarded as a whole.

Every packet starts with a four-word header:
- word 0: target address
- word 1: source address
- word 2: type byte and a spare byte
- word 3: payload length in bytes

The payload of ceil(length/2) words follows the header. The receive side checks the word count of each packet it accepts against this length. Error conditions are kept as sticky status flags that the CPU clears by writing 1 to them. A separate interrupt-status vector reports buffer state and one-cycle event pulses, both as a register and as a port.

Top module: `pkt_endpoint`

## Requirements
- R1: After reset, the status register reads 0x0000, the control register reads 0x0000 and the interrupt register reads 0x0020 (only the transmit-free bit set).
- R2: Words written to the transmit data register (address 2) are delivered in write order to the receive data register (address 3) after a write to control (address 0) with bit 15 (flush) and bit 12 (receive enable) set.
- R3: Status bit 15 (available), bit 13 (first) and bit 12 (last) describe the word at the head of the receive buffer. Each read of the receive data register pops one word. A read of the receive data register while the buffer is empty returns 0x0000 and pops nothing.
- R4: Status bit 8 (length error) is set when an accepted packet's word count differs from 4 + ceil(L/2), where L is header word 3. A packet shorter than 4 words also sets this bit.
- R5: A packet flushed while the receive enable bit is 0, or while the receive buffer has fewer free words than the packet holds, stores no word and sets status bit 11 (dropped).
- R6: Status bit 3 (transmit error) is set by any of these: a flush while the transmit buffer is empty, a transmit data write while the buffer is full, or a transmit data write while a packet is being sent.
- R7: Writing status (address 1) with a 1 in bit 3, 8 or 11 clears that flag. Writing 0 to a flag leaves it unchanged.
- R8: The interrupt register (address 5) and the irqVec port carry these bits:
  - bit 5: transmit idle and empty
  - bit 6: one-cycle pulse when a packet's last word is sent
  - bit 7: one-cycle pulse when an accepted packet's last word is stored
  - bit 8: receive data available
- R9: Status bit 0 is set while the transmit buffer holds words and is not sending. Bit 1 is set while sending. Bit 2 is set when the transmit buffer holds 128 words.
- R10: The flush bit reads back as 0, and control reads back only bit 12. The device address register (address 4) returns the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (pops the receive buffer at address 3) |
| addr | input | 3 | Register select: 0 control, 1 status, 2 tx data, 3 rx data, 4 device address, 5 interrupt |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the selected register, combinational |
| irqVec | output | 16 | Interrupt status vector |

## Verification
The receive-full drop is the case hardest to reach from the ports. A packet is refused only when the room left in the receive buffer at the moment of flush is smaller than the packet. The bench gets there by leaving a 100-word packet undrained and then flushing a 40-word packet. It then proves that nothing of the second packet was stored by draining and counting exactly 100 words. Random packets with deliberately wrong lengths cover the length check. A 128-word packet covers the full-buffer boundary of the transmit side.

// File: rtl/pkt_ep_pkg.sv
package pkt_ep_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_STATUS  = 3'd1,
    REG_TXDATA  = 3'd2,
    REG_RXDATA  = 3'd3,
    REG_DEVADDR = 3'd4,
    REG_IRQ     = 3'd5
  } regSel_e;

  // Bit positions decoded by software
  localparam int ST_TX_BUILD = 0;
  localparam int ST_TX_BUSY  = 1;
  localparam int ST_TX_FULL  = 2;
  localparam int ST_TX_ERR   = 3;
  localparam int ST_LEN_ERR  = 8;
  localparam int ST_DROPPED  = 11;
  localparam int ST_RX_LAST  = 12;
  localparam int ST_RX_FIRST = 13;
  localparam int ST_RX_AVAIL = 15;
  localparam int CT_RX_EN    = 12;
  localparam int CT_FLUSH    = 15;
  localparam int IQ_TX_FREE  = 5;
  localparam int IQ_TX_DONE  = 6;
  localparam int IQ_RX_NEW   = 7;
  localparam int IQ_RX_AVAIL = 8;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic firstWord;
    logic lastWord;
  } epStrobe_t;
endpackage

// File: rtl/pkt_ep_fifo.sv
module pkt_ep_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [AW:0]   count,
  output logic          empty
);
  localparam logic [AW:0] FULL_V = DEPTH[AW:0];

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  assign dout  = mem[rdPtr];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != FULL_V) || pop);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
endmodule

// File: rtl/pkt_ep_datapath.sv
module pkt_ep_datapath
  import pkt_ep_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  epStrobe_t         strobe,
  input  logic [WORD_W-1:0] wrData,
  output logic [AW:0]       txCount,
  output logic              txEmpty,
  output logic [AW:0]       rxCount,
  output logic              rxEmpty,
  output logic [WORD_W-1:0] rxHead,
  output logic              headFirst,
  output logic              headLast,
  output logic              lenErrEvt
);
  logic [WORD_W-1:0] txWord;
  logic [WORD_W+1:0] rxDout;
  logic [AW:0]       wordIdx;
  logic [WORD_W-1:0] lenField, curLen;
  logic [WORD_W:0]   lenPlus, expectWords, gotWords;

  pkt_ep_fifo #(.W(WORD_W), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(strobe.txPop),
    .din(wrData), .dout(txWord), .count(txCount), .empty(txEmpty));

  pkt_ep_fifo #(.W(WORD_W + 2), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(strobe.rxPop),
    .din({strobe.firstWord, strobe.lastWord, txWord}),
    .dout(rxDout), .count(rxCount), .empty(rxEmpty));

  assign rxHead    = rxDout[WORD_W-1:0];
  assign headLast  = rxDout[WORD_W];
  assign headFirst = rxDout[WORD_W+1];

  // Length check on the stream leaving the transmit buffer
  assign curLen      = (wordIdx == (AW+1)'(3)) ? txWord : lenField;
  assign lenPlus     = {1'b0, curLen} + 17'd1;
  assign expectWords = 17'd4 + {1'b0, lenPlus[WORD_W:1]};
  assign gotWords    = 17'(wordIdx) + 17'd1;
  assign lenErrEvt   = strobe.rxPush && strobe.lastWord &&
                       ((wordIdx < (AW+1)'(3)) || (gotWords != expectWords));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      lenField <= '0;
    end else if (strobe.txPop) begin
      wordIdx <= strobe.lastWord ? '0 : wordIdx + 1'b1;
      if (wordIdx == (AW+1)'(3)) lenField <= txWord;
    end
  end

  assert_first_at_index0_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.txPop && strobe.firstWord) |-> (wordIdx == '0));
endmodule

// File: rtl/pkt_ep_ctrl.sv
module pkt_ep_ctrl
  import pkt_ep_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW:0]       txCount,
  input  logic              txEmpty,
  input  logic [AW:0]       rxCount,
  input  logic              rxEmpty,
  input  logic [WORD_W-1:0] rxHead,
  input  logic              headFirst,
  input  logic              headLast,
  input  logic              lenErrEvt,
  output epStrobe_t         strobe,
  output logic [WORD_W-1:0] rdData,
  output logic [WORD_W-1:0] irqVec
);
  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic              rxEnable, txActive, firstPend, acceptPkt;
  logic [AW:0]       txRemain, rxRoom;
  logic [WORD_W-1:0] devAddr, statusWord;
  logic              txErrFlag, lenErrFlag, dropFlag;
  logic              wrCtrl, wrStatus, wrTx, flushReq, startTx, acceptNow;
  logic              txFull, txErrSet, dropSet;

  assign wrCtrl    = wrEn && (addr == REG_CTRL);
  assign wrStatus  = wrEn && (addr == REG_STATUS);
  assign wrTx      = wrEn && (addr == REG_TXDATA);
  assign flushReq  = wrCtrl && wrData[CT_FLUSH];
  assign txFull    = (txCount == DEPTH_V);
  assign startTx   = flushReq && !txActive && !txEmpty;
  assign rxRoom    = DEPTH_V - rxCount;
  assign acceptNow = wrData[CT_RX_EN] && (rxRoom >= txCount);
  assign txErrSet  = (flushReq && !startTx) || (wrTx && (txFull || txActive));
  assign dropSet   = startTx && !acceptNow;

  always_comb begin
    strobe.txPush    = wrTx && !txFull && !txActive;
    strobe.txPop     = txActive;
    strobe.rxPush    = txActive && acceptPkt;
    strobe.rxPop     = rdEn && (addr == REG_RXDATA) && !rxEmpty;
    strobe.firstWord = txActive && firstPend;
    strobe.lastWord  = txActive && (txRemain == (AW+1)'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive  <= 1'b0;
      txRemain  <= '0;
      firstPend <= 1'b0;
      acceptPkt <= 1'b0;
    end else if (startTx) begin
      txActive  <= 1'b1;
      txRemain  <= txCount;
      firstPend <= 1'b1;
      acceptPkt <= acceptNow;
    end else if (txActive) begin
      firstPend <= 1'b0;
      txRemain  <= txRemain - 1'b1;
      if (txRemain == (AW+1)'(1)) txActive <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable   <= 1'b0;
      devAddr    <= '0;
      txErrFlag  <= 1'b0;
      lenErrFlag <= 1'b0;
      dropFlag   <= 1'b0;
    end else begin
      if (wrCtrl) rxEnable <= wrData[CT_RX_EN];
      if (wrEn && (addr == REG_DEVADDR)) devAddr <= wrData;
      txErrFlag  <= txErrSet  | (txErrFlag  & ~(wrStatus & wrData[ST_TX_ERR]));
      lenErrFlag <= lenErrEvt | (lenErrFlag & ~(wrStatus & wrData[ST_LEN_ERR]));
      dropFlag   <= dropSet   | (dropFlag   & ~(wrStatus & wrData[ST_DROPPED]));
    end
  end

  always_comb begin
    statusWord              = '0;
    statusWord[ST_TX_BUILD] = !txEmpty && !txActive;
    statusWord[ST_TX_BUSY]  = txActive;
    statusWord[ST_TX_FULL]  = txFull;
    statusWord[ST_TX_ERR]   = txErrFlag;
    statusWord[ST_LEN_ERR]  = lenErrFlag;
    statusWord[ST_DROPPED]  = dropFlag;
    statusWord[ST_RX_LAST]  = !rxEmpty && headLast;
    statusWord[ST_RX_FIRST] = !rxEmpty && headFirst;
    statusWord[ST_RX_AVAIL] = !rxEmpty;
    irqVec                  = '0;
    irqVec[IQ_TX_FREE]      = !txActive && txEmpty;
    irqVec[IQ_TX_DONE]      = strobe.lastWord;
    irqVec[IQ_RX_NEW]       = strobe.lastWord && acceptPkt;
    irqVec[IQ_RX_AVAIL]     = !rxEmpty;
    case (addr)
      REG_CTRL:    rdData = WORD_W'(rxEnable) << CT_RX_EN;
      REG_STATUS:  rdData = statusWord;
      REG_RXDATA:  rdData = rxEmpty ? '0 : rxHead;
      REG_DEVADDR: rdData = devAddr;
      REG_IRQ:     rdData = irqVec;
      default:     rdData = '0;
    endcase
  end

  assert_start_on_flush_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(flushReq));
  assert_w1c_dropped_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStatus && wrData[ST_DROPPED] && !dropSet) |=> !dropFlag);
  assert_push_counts_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txPush |=> !txEmpty);
endmodule

// File: rtl/pkt_endpoint.sv
module pkt_endpoint
  import pkt_ep_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [2:0]  addr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic [15:0] irqVec
);
  localparam int AW = $clog2(DEPTH);

  epStrobe_t         strobe;
  logic [AW:0]       txCount, rxCount;
  logic              txEmpty, rxEmpty, headFirst, headLast, lenErrEvt;
  logic [WORD_W-1:0] rxHead;

  pkt_ep_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .txCount(txCount), .txEmpty(txEmpty),
    .rxCount(rxCount), .rxEmpty(rxEmpty), .rxHead(rxHead),
    .headFirst(headFirst), .headLast(headLast), .lenErrEvt(lenErrEvt),
    .strobe(strobe), .rdData(rdData), .irqVec(irqVec));

  pkt_ep_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .txCount(txCount), .txEmpty(txEmpty), .rxCount(rxCount),
    .rxEmpty(rxEmpty), .rxHead(rxHead), .headFirst(headFirst),
    .headLast(headLast), .lenErrEvt(lenErrEvt));
endmodule

// File: tb/sim_pkt_endpoint.sv
`timescale 1ns/1ps
module sim_pkt_endpoint;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData, irqVec;

  int checks = 0, fails = 0;
  int doneCnt = 0, newCnt = 0;
  logic [15:0] pkt [0:255];
  int pktN = 0;

  always #2.5 clk = ~clk;

  pkt_endpoint u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
                   .addr(addr), .wrData(wrData), .rdData(rdData), .irqVec(irqVec));

  always @(negedge clk) begin
    if (rstN) begin
      if (irqVec[6]) doneCnt++;
      if (irqVec[7]) newCnt++;
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic int wordsFor(input int lenBytes);
    return 4 + (lenBytes + 1) / 2;
  endfunction

  // Build a packet with a length field and an actual word count
  task automatic build(input int lenBytes, input int nWords);
    pkt[0] = 16'($urandom);
    pkt[1] = 16'h0001;
    pkt[2] = 16'($urandom);
    pkt[3] = 16'(lenBytes);
    for (int i = 4; i < nWords; i++) pkt[i] = 16'($urandom);
    pktN = nWords;
  endtask

  task automatic loadTx();
    for (int i = 0; i < pktN; i++) wr(3'd2, pkt[i]);
  endtask

  // Drain all words, check data and head flags against pkt
  task automatic drainCheck(input string tag, output int got);
    logic [15:0] st, d;
    got = 0;
    rd(3'd1, st);
    while (st[15]) begin
      logic [15:0] expFlags;
      expFlags = 16'h8000 | (got == 0 ? 16'h2000 : 16'h0) |
                 (got == pktN - 1 ? 16'h1000 : 16'h0);
      check({tag, " R3 head flags"}, st & 16'hF000, expFlags);
      rd(3'd3, d);
      if (got < pktN) check({tag, " R2 data"}, d, pkt[got]);
      got++;
      rd(3'd1, st);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int got, d0, n0, lenB, nW;
    bit bad;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(3'd1, v); check("R1 status", v, 16'h0000);
    rd(3'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(3'd5, v); check("R1 irq", v, 16'h0020);

    // R10 control readback and device address
    wr(3'd0, 16'h9000);
    rd(3'd0, v); check("R10 ctrl readback", v, 16'h1000);
    wr(3'd4, 16'hA5C3);
    rd(3'd4, v); check("R10 devaddr", v, 16'hA5C3);

    // R6 flush with empty tx buffer (the write above), R7 clearing
    rd(3'd1, v); check("R6 tx err on empty flush", v & 16'h0008, 16'h0008);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); check("R7 write 0 keeps", v & 16'h0008, 16'h0008);
    wr(3'd1, 16'h0008);
    rd(3'd1, v); check("R7 write 1 clears", v, 16'h0000);

    // Random packets, some with wrong length
    for (int p = 0; p < 20; p++) begin
      lenB = $urandom % 80;
      bad  = ($urandom % 4) == 0;
      nW   = wordsFor(lenB) + (bad ? 1 : 0);
      build(lenB, nW);
      loadTx();
      rd(3'd1, v); check("R9 building", v & 16'h0007, 16'h0001);
      d0 = doneCnt; n0 = newCnt;
      wr(3'd0, 16'h9000);
      repeat (nW + 3) @(negedge clk);
      check("R8 tx done pulse", 16'(doneCnt - d0), 16'd1);
      check("R8 rx new pulse", 16'(newCnt - n0), 16'd1);
      rd(3'd5, v); check("R8 irq idle", v & 16'h01E0, 16'h0120);
      rd(3'd1, v); check("R4 length flag", v & 16'h0100, bad ? 16'h0100 : 16'h0000);
      drainCheck("rand", got);
      check("R2 word count", 16'(got), 16'(nW));
      rd(3'd3, v); check("R3 empty read", v, 16'h0000);
      wr(3'd1, 16'h0908);
      rd(3'd1, v); check("R7 clear all", v, 16'h0000);
    end

    // R4 packet shorter than a header
    build(0, 2); loadTx();
    wr(3'd0, 16'h9000);
    repeat (6) @(negedge clk);
    rd(3'd1, v); check("R4 short packet", v & 16'h0100, 16'h0100);
    drainCheck("short", got);
    wr(3'd1, 16'h0908);

    // R5 no room: keep a 100-word packet, then flush 40 words
    build(192, 100); loadTx();
    wr(3'd0, 16'h9000);
    repeat (104) @(negedge clk);
    build(72, 40);
    for (int i = 0; i < pktN; i++) wr(3'd2, 16'hDEAD);
    n0 = newCnt; d0 = doneCnt;
    wr(3'd0, 16'h9000);
    repeat (44) @(negedge clk);
    check("R8 tx done on drop", 16'(doneCnt - d0), 16'd1);
    check("R8 no rx new on drop", 16'(newCnt - n0), 16'd0);
    rd(3'd1, v); check("R5 dropped flag", v & 16'h0800, 16'h0800);
    got = 0;
    rd(3'd1, v);
    while (v[15]) begin
      logic [15:0] dd;
      rd(3'd3, dd);
      if (dd == 16'hDEAD) check("R5 dropped word stored", dd, 16'h0000);
      got++;
      rd(3'd1, v);
    end
    check("R5 only first packet kept", 16'(got), 16'd100);
    wr(3'd1, 16'h0800);

    // R5 receive disabled
    build(10, 9); loadTx();
    wr(3'd0, 16'h8000);
    repeat (12) @(negedge clk);
    rd(3'd1, v); check("R5 rx disabled drop", v & 16'h8800, 16'h0800);
    wr(3'd1, 16'h0800);

    // R9/R6 full transmit buffer, 128 words
    build(248, 128); loadTx();
    rd(3'd1, v); check("R9 full flag", v & 16'h0007, 16'h0005);
    rd(3'd5, v); check("R8 tx not free", v & 16'h0020, 16'h0000);
    wr(3'd2, 16'h1111);
    rd(3'd1, v); check("R6 write when full", v & 16'h0008, 16'h0008);
    wr(3'd1, 16'h0008);
    wr(3'd0, 16'h9000);
    rd(3'd1, v); check("R9 transmitting", v & 16'h000B, 16'h0002);
    wr(3'd2, 16'h2222);
    rd(3'd1, v); check("R6 write while sending", v & 16'h0008, 16'h0008);
    repeat (130) @(negedge clk);
    rd(3'd1, v); check("R4 no length error", v & 16'h0100, 16'h0000);
    drainCheck("full", got);
    check("R2 full packet count", 16'(got), 16'd128);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule